// File: doc/BRIEF.md
# Descriptor-Driven Single-Channel Transfer Engine

This block moves one data item per activation. The block keeps no channel state of its own between activations. All of that state sits in an eight-byte descriptor in memory. The descriptor holds four 16-bit words: a control word, a source pointer, a destination pointer and a remaining-transfer count.

An activation presents a descriptor pointer. The engine reads the four words and performs one byte or 16-bit move through a request/ready memory port. It then writes the advanced pointers and the reduced count back into the descriptor. A one-cycle end pulse marks each finished activation. A second pulse marks the activation that brings the count to zero.

A pointer whose descriptor would run past the top of the 16-bit address space is refused at once. In that case an error pulse is raised and no memory access is made. If any reserved control bit is set, a sticky status flag is raised, but the move is still carried out.

Top module: `desc_xfer_engine`

## Requirements
- R1: While reset is held, and after it is released, `busy`, `mem_req`, `xfer_end`, `done_pulse`, `ptr_err` and `rsv_flag` are all low.
- R2: Every accepted activation makes exactly nine memory accesses in this order: reads at pointer+0 (control), +2 (source), +4 (destination) and +6 (count), then a read of the source, a write of the destination, and writes at +2, +4 and +6. All descriptor accesses use both byte strobes.
- R3: Bit 15 of the control word picks the size: 1 for a 16-bit move, 0 for a byte move. A byte access uses strobe `01` (data bits 7:0) when address bit 0 is 0, and strobe `10` (data bits 15:8) when it is 1. The byte taken from the source lane lands in the destination lane, and the other destination byte is left unchanged.
- R4: Bit 14 enables source pointer advance and bit 13 enables destination pointer advance. The advance is 2 for 16-bit moves and 1 for byte moves, modulo 2^16. A disabled pointer is written back unchanged.
- R5: The count is written back reduced by one modulo 2^16, so a stored 0 (meaning 65536 moves) becomes 0xFFFF.
- R6: `xfer_end` is high for exactly one cycle per completed activation. `done_pulse` is high in that same cycle only when the written-back count is 0.
- R7: If any of control bits 12 to 0 is set, `rsv_flag` is high by the time `xfer_end` pulses and the move still takes place. The flag is cleared when the next activation is accepted.
- R8: A pointer above 0xFFF8 makes `ptr_err` pulse for one cycle, in the cycle after the request. The engine makes no memory access and `busy` stays low.
- R9: `busy` rises in the cycle after an activation is accepted and falls in the cycle where `xfer_end` pulses. An activation request seen while `busy` is high is ignored.
- R10: Once `mem_req` is raised, it is held, together with the address, direction, strobes and write data, until `mem_rdy` is sampled high at a rising clock edge. That edge completes the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_req | input | 1 | Activation request |
| act_ptr | input | 16 | Descriptor pointer for the request |
| busy | output | 1 | Activation in progress |
| xfer_end | output | 1 | One-cycle pulse when an activation finishes |
| done_pulse | output | 1 | One-cycle pulse when the count reaches zero |
| rsv_flag | output | 1 | Reserved control bits were set in the current or last descriptor |
| ptr_err | output | 1 | One-cycle pulse for a refused pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_be | output | 2 | Byte strobes, bit 0 for data bits 7:0 |
| mem_rdata | input | 16 | Memory read data, valid with mem_rdy |
| mem_rdy | input | 1 | Access completes at an edge where this is high |

## Verification
The bench goes after the byte lanes with odd and even source and destination addresses. A design that mixed up the lanes would corrupt the neighbouring destination byte or move the wrong half-word. It drives counts of 1 and 0: a wrong decrement or compare would either miss the done pulse or fire it on the wrap from 0 to 0xFFFF. It drives pointers 0xFFF8, 0xFFF9 and 0xFFFF, where an off-by-one boundary would either refuse a legal descriptor or access memory past the page end. It also raises a second request mid-activation, which a design that did not guard its idle state would act on, and it stalls `mem_rdy` at random so that any access ending before ready would corrupt data.

// File: rtl/dxe_pkg.sv
package dxe_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_F_MODE,
    ST_F_SRC,
    ST_F_DST,
    ST_F_CNT,
    ST_RD,
    ST_WR,
    ST_WB_SRC,
    ST_WB_DST,
    ST_WB_CNT
  } dxe_state_e;

  // descriptor layout, in words
  localparam int unsigned DESC_WORDS = 4;
  localparam int unsigned WIX_MODE   = 0;
  localparam int unsigned WIX_SRC    = 1;
  localparam int unsigned WIX_DST    = 2;
  localparam int unsigned WIX_CNT    = 3;

endpackage

// File: rtl/dxe_mode_decode.sv
module dxe_mode_decode #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] mode,
  output logic              is_word,
  output logic              src_inc,
  output logic              dst_inc,
  output logic              rsv_set
);
  localparam int SIZE_BIT = DATA_W - 1;
  localparam int SINC_BIT = DATA_W - 2;
  localparam int DINC_BIT = DATA_W - 3;

  assign is_word = mode[SIZE_BIT];
  assign src_inc = mode[SINC_BIT];
  assign dst_inc = mode[DINC_BIT];
  assign rsv_set = |mode[DINC_BIT-1:0];
endmodule

// File: rtl/dxe_addr_step.sv
module dxe_addr_step #(
  parameter int ADDR_W     = 16,
  parameter int WORD_BYTES = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              inc,
  input  logic              is_word,
  output logic [ADDR_W-1:0] addr_nx
);
  logic [ADDR_W-1:0] step;

  always_comb begin
    step = '0;
    if (inc) begin
      step = is_word ? ADDR_W'(WORD_BYTES) : ADDR_W'(1);
    end
  end

  assign addr_nx = addr + step;
endmodule

// File: rtl/dxe_lane.sv
module dxe_lane #(
  parameter  int DATA_W = 16,
  localparam int BE_W   = DATA_W / 8,
  localparam int SEL_W  = (BE_W > 1) ? $clog2(BE_W) : 1
) (
  input  logic              is_word,
  input  logic [SEL_W-1:0]  rd_sel,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] rd_raw,
  input  logic [DATA_W-1:0] wr_val,
  output logic [DATA_W-1:0] rd_val,
  output logic [DATA_W-1:0] wr_data,
  output logic [BE_W-1:0]   rd_be,
  output logic [BE_W-1:0]   wr_be
);
  logic [7:0] rd_byte;

  always_comb begin
    rd_byte = rd_raw[8*int'(rd_sel) +: 8];
  end

  assign rd_val = is_word ? rd_raw : DATA_W'(rd_byte);

  for (genvar l = 0; l < BE_W; l++) begin : g_lane
    assign rd_be[l]          = is_word | (rd_sel == SEL_W'(l));
    assign wr_be[l]          = is_word | (wr_sel == SEL_W'(l));
    assign wr_data[8*l +: 8] = is_word ? wr_val[8*l +: 8] : wr_val[7:0];
  end

  // a byte write touches exactly one lane
  always_comb begin
    if (is_word === 1'b0) begin
      assert_byte_lane_R3: assert ($countones(wr_be) == 1);
    end
  end
endmodule

// File: rtl/desc_xfer_engine.sv
module desc_xfer_engine
  import dxe_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  act_req,
  input  logic [ADDR_W-1:0]     act_ptr,
  output logic                  busy,
  output logic                  xfer_end,
  output logic                  done_pulse,
  output logic                  rsv_flag,
  output logic                  ptr_err,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W-1:0]     mem_wdata,
  output logic [DATA_W/8-1:0]   mem_be,
  input  logic [DATA_W-1:0]     mem_rdata,
  input  logic                  mem_rdy
);
  localparam int BE_W  = DATA_W / 8;
  localparam int SEL_W = (BE_W > 1) ? $clog2(BE_W) : 1;
  localparam logic [ADDR_W-1:0] PTR_LAST =
    ADDR_W'((longint'(1) << ADDR_W) - longint'(DESC_WORDS * BE_W));
  localparam logic [ADDR_W-1:0] OFS_SRC = ADDR_W'(WIX_SRC * BE_W);
  localparam logic [ADDR_W-1:0] OFS_DST = ADDR_W'(WIX_DST * BE_W);
  localparam logic [ADDR_W-1:0] OFS_CNT = ADDR_W'(WIX_CNT * BE_W);

  // reset: asserted asynchronously, released on the clock
  logic rs_meta, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta   <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rs_meta   <= 1'b1;
      rst_int_n <= rs_meta;
    end
  end

  dxe_state_e        state_q, state_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [DATA_W-1:0] mode_q, mode_d;
  logic [ADDR_W-1:0] src_q, src_d;
  logic [ADDR_W-1:0] dst_q, dst_d;
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              rsv_q, rsv_d;
  logic              last_q, last_d;
  logic              end_q, end_d;
  logic              done_q, done_d;
  logic              perr_q, perr_d;

  logic dec_word, dec_sinc, dec_dinc, dec_rsv;
  logic acc_done;

  dxe_mode_decode #(.DATA_W(DATA_W)) u_mode (
    .mode    (mode_q),
    .is_word (dec_word),
    .src_inc (dec_sinc),
    .dst_inc (dec_dinc),
    .rsv_set (dec_rsv)
  );

  // pointer advance, one stepper per endpoint
  logic [ADDR_W-1:0] ep_addr [2];
  logic              ep_inc  [2];
  logic [ADDR_W-1:0] ep_nx   [2];

  assign ep_addr[0] = src_q;
  assign ep_addr[1] = dst_q;
  assign ep_inc[0]  = dec_sinc;
  assign ep_inc[1]  = dec_dinc;

  for (genvar e = 0; e < 2; e++) begin : g_ep
    dxe_addr_step #(.ADDR_W(ADDR_W), .WORD_BYTES(BE_W)) u_step (
      .addr    (ep_addr[e]),
      .inc     (ep_inc[e]),
      .is_word (dec_word),
      .addr_nx (ep_nx[e])
    );
  end

  logic [DATA_W-1:0] ln_rd_val, ln_wr_data;
  logic [BE_W-1:0]   ln_rd_be, ln_wr_be;

  dxe_lane #(.DATA_W(DATA_W)) u_lane (
    .is_word (dec_word),
    .rd_sel  (src_q[SEL_W-1:0]),
    .wr_sel  (dst_q[SEL_W-1:0]),
    .rd_raw  (mem_rdata),
    .wr_val  (data_q),
    .rd_val  (ln_rd_val),
    .wr_data (ln_wr_data),
    .rd_be   (ln_rd_be),
    .wr_be   (ln_wr_be)
  );

  assign acc_done = mem_req & mem_rdy;

  // next-state
  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    mode_d  = mode_q;
    src_d   = src_q;
    dst_d   = dst_q;
    cnt_d   = cnt_q;
    data_d  = data_q;
    rsv_d   = rsv_q;
    last_d  = last_q;
    end_d   = 1'b0;
    done_d  = 1'b0;
    perr_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (act_req) begin
          if (act_ptr > PTR_LAST) begin
            perr_d = 1'b1;
          end else begin
            state_d = ST_F_MODE;
            ptr_d   = act_ptr;
            rsv_d   = 1'b0;
          end
        end
      end
      ST_F_MODE: if (acc_done) begin
        mode_d  = mem_rdata;
        state_d = ST_F_SRC;
      end
      ST_F_SRC: if (acc_done) begin
        src_d   = mem_rdata[ADDR_W-1:0];
        rsv_d   = dec_rsv;
        state_d = ST_F_DST;
      end
      ST_F_DST: if (acc_done) begin
        dst_d   = mem_rdata[ADDR_W-1:0];
        state_d = ST_F_CNT;
      end
      ST_F_CNT: if (acc_done) begin
        cnt_d   = mem_rdata;
        state_d = ST_RD;
      end
      ST_RD: if (acc_done) begin
        data_d  = ln_rd_val;
        state_d = ST_WR;
      end
      ST_WR: if (acc_done) begin
        src_d   = ep_nx[0];
        dst_d   = ep_nx[1];
        cnt_d   = cnt_q - DATA_W'(1);
        last_d  = (cnt_q == DATA_W'(1));
        state_d = ST_WB_SRC;
      end
      ST_WB_SRC: if (acc_done) state_d = ST_WB_DST;
      ST_WB_DST: if (acc_done) state_d = ST_WB_CNT;
      ST_WB_CNT: if (acc_done) begin
        state_d = ST_IDLE;
        end_d   = 1'b1;
        done_d  = last_q;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      mode_q  <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      data_q  <= '0;
      rsv_q   <= 1'b0;
      last_q  <= 1'b0;
      end_q   <= 1'b0;
      done_q  <= 1'b0;
      perr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      mode_q  <= mode_d;
      src_q   <= src_d;
      dst_q   <= dst_d;
      cnt_q   <= cnt_d;
      data_q  <= data_d;
      rsv_q   <= rsv_d;
      last_q  <= last_d;
      end_q   <= end_d;
      done_q  <= done_d;
      perr_q  <= perr_d;
    end
  end

  // memory port, decoded from the state
  always_comb begin
    mem_req   = 1'b1;
    mem_we    = 1'b0;
    mem_addr  = ptr_q;
    mem_wdata = '0;
    mem_be    = '1;
    case (state_q)
      ST_F_MODE: mem_addr = ptr_q;
      ST_F_SRC:  mem_addr = ptr_q + OFS_SRC;
      ST_F_DST:  mem_addr = ptr_q + OFS_DST;
      ST_F_CNT:  mem_addr = ptr_q + OFS_CNT;
      ST_RD: begin
        mem_addr = src_q;
        mem_be   = ln_rd_be;
      end
      ST_WR: begin
        mem_addr  = dst_q;
        mem_we    = 1'b1;
        mem_wdata = ln_wr_data;
        mem_be    = ln_wr_be;
      end
      ST_WB_SRC: begin
        mem_addr  = ptr_q + OFS_SRC;
        mem_we    = 1'b1;
        mem_wdata = DATA_W'(src_q);
      end
      ST_WB_DST: begin
        mem_addr  = ptr_q + OFS_DST;
        mem_we    = 1'b1;
        mem_wdata = DATA_W'(dst_q);
      end
      ST_WB_CNT: begin
        mem_addr  = ptr_q + OFS_CNT;
        mem_we    = 1'b1;
        mem_wdata = cnt_q;
      end
      default: mem_req = 1'b0;
    endcase
  end

  assign busy       = (state_q != ST_IDLE);
  assign xfer_end   = end_q;
  assign done_pulse = done_q;
  assign rsv_flag   = rsv_q;
  assign ptr_err    = perr_q;

  // checks on the port and sequencing behaviour
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata) && $stable(mem_be)));

  assert_done_in_end_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_pulse |-> xfer_end);

  assert_end_single_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    xfer_end |=> !xfer_end);

  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    ptr_err |-> (!busy && !mem_req));

  assert_ptr_kept_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    busy |=> (!busy || $stable(ptr_q)));
endmodule

// File: tb/desc_xfer_engine_tb.sv
`timescale 1ns/1ps
module desc_xfer_engine_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        act_req;
  logic [15:0] act_ptr;
  logic        busy, xfer_end, done_pulse, rsv_flag, ptr_err;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_be;
  logic        mem_rdy = 1'b0;

  always #2.5 clk = ~clk;

  desc_xfer_engine u_dut (
    .clk(clk), .rst_n(rst_n), .act_req(act_req), .act_ptr(act_ptr),
    .busy(busy), .xfer_end(xfer_end), .done_pulse(done_pulse),
    .rsv_flag(rsv_flag), .ptr_err(ptr_err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata),
    .mem_rdy(mem_rdy)
  );

  // memory model: 512 words, address bits above 9 alias
  logic [15:0] mem [0:511];
  logic        tb_we = 1'b0;
  logic [15:0] tb_wa, tb_wd;
  logic [15:0] log_a [0:1023];
  logic        log_w [0:1023];
  logic [1:0]  log_b [0:1023];
  int          log_n = 0;
  int          hs_bad = 0;
  logic        pend_q = 1'b0;
  logic [15:0] pa_q, pd_q;

  function automatic logic [8:0] mi(input logic [15:0] a);
    return a[9:1];
  endfunction

  assign mem_rdata = mem[mi(mem_addr)];

  always @(posedge clk) begin
    if (tb_we) mem[mi(tb_wa)] <= tb_wd;
    if (mem_req === 1'b1 && mem_rdy) begin
      if (mem_we) begin
        if (mem_be[0]) mem[mi(mem_addr)][7:0]  <= mem_wdata[7:0];
        if (mem_be[1]) mem[mi(mem_addr)][15:8] <= mem_wdata[15:8];
      end
      log_a[log_n % 1024] <= mem_addr;
      log_w[log_n % 1024] <= mem_we;
      log_b[log_n % 1024] <= mem_be;
      log_n <= log_n + 1;
    end
    if (pend_q && (mem_req !== 1'b1 || mem_addr !== pa_q || mem_wdata !== pd_q))
      hs_bad <= hs_bad + 1;
    pend_q <= (mem_req === 1'b1) && !mem_rdy;
    pa_q   <= mem_addr;
    pd_q   <= mem_wdata;
  end

  always @(negedge clk) mem_rdy <= ($urandom_range(3) != 0);

  int  n_chk = 0;
  int  n_bad = 0;
  bit  reported = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // called at a falling edge
  task automatic poke(input logic [15:0] a, input logic [15:0] d);
    tb_we = 1'b1; tb_wa = a; tb_wd = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic setup(input logic [15:0] p, input logic [15:0] mode,
                       input logic [15:0] s, input logic [15:0] d,
                       input logic [15:0] c);
    poke(p, mode);
    poke(p + 16'd2, s);
    poke(p + 16'd4, d);
    poke(p + 16'd6, c);
    poke(s, 16'($urandom));
    poke(d, 16'($urandom));
  endtask

  task automatic run_act(input logic [15:0] p, input bit intrude,
                         input logic [15:0] p2);
    logic [15:0] mode, s, d, c, val, old, exp_dw, exp_s, exp_d, exp_c, step;
    logic [15:0] p2_cnt;
    logic [15:0] ea [9];
    logic [1:0]  sbe, dbe;
    bit exp_done, exp_rsv, isw, seq_ok, be_ok;
    int start, waited;
    start = log_n;
    if (p > 16'hFFF8) begin
      act_req = 1'b1; act_ptr = p;
      @(negedge clk);
      act_req = 1'b0;
      check(ptr_err === 1'b1, "R8", "error pulse", 32'(ptr_err), 1);
      check(busy === 1'b0, "R8", "busy on bad pointer", 32'(busy), 0);
      @(negedge clk);
      check(ptr_err === 1'b0, "R8", "error pulse length", 32'(ptr_err), 0);
      repeat (4) @(negedge clk);
      check(log_n == start, "R8", "accesses on bad pointer", 32'(log_n - start), 0);
      return;
    end
    mode = mem[mi(p)]; s = mem[mi(p + 16'd2)];
    d = mem[mi(p + 16'd4)]; c = mem[mi(p + 16'd6)];
    isw  = mode[15];
    step = isw ? 16'd2 : 16'd1;
    old  = mem[mi(d)];
    val  = mem[mi(s)];
    if (!isw) val = s[0] ? {8'h00, val[15:8]} : {8'h00, val[7:0]};
    if (isw)       exp_dw = val;
    else if (d[0]) exp_dw = {val[7:0], old[7:0]};
    else           exp_dw = {old[15:8], val[7:0]};
    exp_s = s + (mode[14] ? step : 16'd0);
    exp_d = d + (mode[13] ? step : 16'd0);
    exp_c = c - 16'd1;
    exp_done = (c == 16'd1);
    exp_rsv  = (mode[12:0] != 13'd0);
    sbe = isw ? 2'b11 : (s[0] ? 2'b10 : 2'b01);
    dbe = isw ? 2'b11 : (d[0] ? 2'b10 : 2'b01);
    p2_cnt = mem[mi(p2 + 16'd6)];
    ea = '{p, p + 16'd2, p + 16'd4, p + 16'd6, s, d, p + 16'd2, p + 16'd4, p + 16'd6};

    act_req = 1'b1; act_ptr = p;
    @(negedge clk);
    act_req = 1'b0;
    check(busy === 1'b1, "R9", "busy after accept", 32'(busy), 1);
    if (intrude) begin
      @(negedge clk);
      act_req = 1'b1; act_ptr = p2;
      @(negedge clk);
      act_req = 1'b0;
    end
    waited = 0;
    while (xfer_end !== 1'b1 && waited < 500) begin
      @(negedge clk);
      waited++;
    end
    check(xfer_end === 1'b1, "R9", "activation completes", 32'(xfer_end), 1);
    check(busy === 1'b0, "R9", "busy at end pulse", 32'(busy), 0);
    check(done_pulse === exp_done, "R6", "done pulse", 32'(done_pulse), 32'(exp_done));
    check(rsv_flag === exp_rsv, "R7", "reserved flag", 32'(rsv_flag), 32'(exp_rsv));
    check(mem[mi(d)] === exp_dw, "R3", "destination word", 32'(mem[mi(d)]), 32'(exp_dw));
    check(mem[mi(p + 16'd2)] === exp_s, "R4", "source writeback",
          32'(mem[mi(p + 16'd2)]), 32'(exp_s));
    check(mem[mi(p + 16'd4)] === exp_d, "R4", "destination writeback",
          32'(mem[mi(p + 16'd4)]), 32'(exp_d));
    check(mem[mi(p + 16'd6)] === exp_c, "R5", "count writeback",
          32'(mem[mi(p + 16'd6)]), 32'(exp_c));
    check(log_n - start == 9, "R2", "access count", 32'(log_n - start), 9);
    seq_ok = 1'b1; be_ok = 1'b1;
    for (int k = 0; k < 9; k++) begin
      if (log_a[(start + k) % 1024] !== ea[k]) seq_ok = 1'b0;
      if (log_w[(start + k) % 1024] !== (k >= 5)) seq_ok = 1'b0;
      if (k == 4) begin
        if (log_b[(start + k) % 1024] !== sbe) be_ok = 1'b0;
      end else if (k == 5) begin
        if (log_b[(start + k) % 1024] !== dbe) be_ok = 1'b0;
      end else if (log_b[(start + k) % 1024] !== 2'b11) be_ok = 1'b0;
    end
    check(seq_ok, "R2", "access order", 32'(seq_ok), 1);
    check(be_ok, "R3", "byte strobes", 32'(be_ok), 1);
    @(negedge clk);
    check(xfer_end === 1'b0 && done_pulse === 1'b0, "R6", "pulse width",
          32'({xfer_end, done_pulse}), 0);
    if (intrude) begin
      bit seen_busy;
      seen_busy = 1'b0;
      for (int k = 0; k < 20; k++) begin
        if (busy !== 1'b0) seen_busy = 1'b1;
        @(negedge clk);
      end
      check(!seen_busy, "R9", "request during busy ignored", 32'(seen_busy), 0);
      check(mem[mi(p2 + 16'd6)] === p2_cnt, "R9", "ignored descriptor untouched",
            32'(mem[mi(p2 + 16'd6)]), 32'(p2_cnt));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    logic [15:0] p, m, s, d, c;
    void'($urandom(32'd24681));
    act_req = 1'b0; act_ptr = '0;
    repeat (4) @(negedge clk);
    check({busy, mem_req, xfer_end, done_pulse, ptr_err, rsv_flag} === 6'b0, "R1",
          "outputs in reset", 32'({busy, mem_req, xfer_end, done_pulse, ptr_err, rsv_flag}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check({busy, mem_req, xfer_end, done_pulse, ptr_err, rsv_flag} === 6'b0, "R1",
          "outputs after reset", 32'({busy, mem_req, xfer_end, done_pulse, ptr_err, rsv_flag}), 0);

    // R3 R4: word move, both pointers advance
    setup(16'h0010, 16'hE000, 16'h0200, 16'h0300, 16'd5);
    run_act(16'h0010, 1'b0, 16'h0);
    // R6: count 1 ends the channel; byte, odd source, even destination
    setup(16'h0018, 16'h4000, 16'h0211, 16'h0320, 16'd1);
    run_act(16'h0018, 1'b0, 16'h0);
    // R5 R7: count 0 wraps, no done; even source, odd destination, reserved bit
    setup(16'h0020, 16'h0004, 16'h0222, 16'h0333, 16'd0);
    run_act(16'h0020, 1'b0, 16'h0);
    // R7: flag cleared by a clean descriptor
    setup(16'h0028, 16'h2000, 16'h0240, 16'h0341, 16'd3);
    run_act(16'h0028, 1'b0, 16'h0);
    // R8: last legal pointer and two refused ones
    setup(16'hFFF8, 16'hC000, 16'h0200, 16'h0300, 16'd2);
    run_act(16'hFFF8, 1'b0, 16'h0);
    run_act(16'hFFF9, 1'b0, 16'h0);
    run_act(16'hFFFF, 1'b0, 16'h0);
    // R9: request during an activation
    setup(16'h0030, 16'h8000, 16'h0250, 16'h0350, 16'd9);
    setup(16'h0038, 16'h8000, 16'h0260, 16'h0360, 16'd7);
    run_act(16'h0030, 1'b1, 16'h0038);

    for (int i = 0; i < 40; i++) begin
      p = 16'($urandom_range(31)) * 16'd8;
      m = 16'($urandom);
      if ($urandom_range(3) != 0) m[12:0] = '0;
      s = 16'h0200 + 16'($urandom_range(255));
      d = 16'h0300 + 16'($urandom_range(255));
      case ($urandom_range(3))
        0: c = 16'd0;
        1: c = 16'd1;
        default: c = 16'($urandom);
      endcase
      setup(p, m, s, d, c);
      run_act(p, 1'b0, 16'h0);
    end

    check(hs_bad == 0, "R10", "request held until ready", 32'(hs_bad), 0);
    report();
  end
endmodule